// File: doc/BRIEF.md
# Touch and Sensor Conversion Scheduler

This block decides when a touch/sensor ADC front end may run a conversion. Software writes a control word that picks a conversion function (4 bits), a precision code (2 bits), a filter byte and an enable. Every cycle the block checks the pen state, the unread-data flags, the enable and the busy state, and when the chosen function is allowed to start it latches the function and the precision and holds busy for a fixed number of clock cycles. When the time is up it ORs a function-specific mask into a 16-bit data-available vector.

The host reads results channel by channel. A read returns the raw 16-bit sample, truncated to the resolution of the precision latched at the last conversion start, and clears that channel's data-available bit. Two active-low interrupt lines are driven: a pen line whose meaning is chosen by a 2-bit pin mode, and a data-available line that is low while any bit is pending. Single-channel functions switch the block off once data is pending. Scan functions stay enabled but wait until every pending bit has been read.

Top module: `touch_conv_sched`

## Requirements
- R1: After reset the block is disabled and idle: `busy`=0, `enabled`=0, `dav`=0, `pen_irq_n`=1, `dav_irq_n`=1, pending function 0, pending precision 0, pen pin mode 2. `ctrl_rdata` then reads 0x4000 while the pen is up.
- R2: Start eligibility by function code. Codes 0x1 to 0x5 start only while `pen_down`=1. Codes 0x6 to 0xC start whatever the pen state. Codes 0x0 and 0xD to 0xF never start.
- R3: Single-channel codes (0x3 to 0x8, 0xA, 0xC) clear `enabled` once `dav` is non-zero (codes 0x3 to 0x5 only while the pen is down). Scan codes 0x1, 0x2, 0x9 and 0xB keep `enabled` set.
- R4: A conversion starts only when enabled, not busy and `dav`=0. At the start the pending function and precision are copied into active copies, and a later control write does not change the running conversion.
- R5: `busy` rises on the clock edge after the enable write has been captured and stays high for exactly CONV_CYCLES cycles. On the edge that clears it, the mask of the active function is ORed into `dav`: 0x0→0, 0x1→0x0600, 0x2→0x0780, 0x3→0x0400, 0x4→0x0200, 0x5→0x0180, 0x6→0x0040, 0x7→0x0030, 0x8→0x0010, 0x9→0x0010, 0xA→0x0004, 0xB→0x0070, 0xC→0x0002, 0xD to 0xF→0. `dav_irq_n` is low exactly while `dav` is non-zero.
- R6: A read with `rd_sel`=c for c in 0..10 clears `dav` bit (10−c) on the read edge. Codes 11 to 15 clear nothing.
- R7: `rd_data`, valid the cycle after `rd_en`, equals `raw_sample` shifted right by 16−res. res is 12, 8, 10 or 12 for precision codes 0, 1, 2, 3 as latched at the last start.
- R8: Pen pin modes: 0 → pin active when the pen is down. 1 → pin active when `dav`≠0. 2 or 3 → pin active when the pen is down and `dav`=0. While disabled the pin is inactive. `pen_irq_n` is the active-low form.
- R9: A control write with bit 14 set disables the block. If a conversion is running it is dropped: `busy` is 0 the next cycle and no `dav` bits are set.
- R10: The control word is written through `cfg_wdata[14:0]`: 14 = disable, 13:10 = function, 9:8 = precision, 7:0 = filter. `ctrl_rdata` reads {pen_down, not busy, function, precision, filter} from bit 15 down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 15 | Control word: disable, function, precision, filter |
| pin_we | input | 1 | Pen pin mode write strobe |
| pin_wdata | input | 2 | Pen pin mode |
| pen_down | input | 1 | Pen pressure, 1 = pressed |
| rd_en | input | 1 | Result read strobe |
| rd_sel | input | 4 | Channel being read (0..10) |
| raw_sample | input | RAW_W | Raw converter sample for the channel being read |
| rd_data | output | RAW_W | Truncated result, registered |
| ctrl_rdata | output | 16 | Control word readback |
| dav | output | 16 | Data-available vector |
| busy | output | 1 | Conversion in progress |
| enabled | output | 1 | Scheduler enabled |
| pen_irq_n | output | 1 | Pen interrupt, active low |
| dav_irq_n | output | 1 | Data-available interrupt, active low |

## Verification
A control write is captured on one edge. The earliest start is the next edge, and `busy` holds for CONV_CYCLES edges after that, so `dav` carries the mask CONV_CYCLES+2 edges after the write strobe was driven. The bench drives inputs on the falling edge and samples on the following falling edge, and it counts those edges one by one in the cycle-exact busy test. Reads clear `dav` and update `rd_data` on the edge that samples `rd_en`, and the pen pin follows its inputs within the same cycle, so those checks sample one falling edge after the stimulus. The sweep over all 16 function codes, with the pen both up and down, waits well past the completion edge before it compares.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

   localparam int FUNC_W = 4;
   localparam int PREC_W = 2;
   localparam int DAV_W  = 16;
   localparam int NUM_CH = 11;
   localparam int PREC_N = 1 << PREC_W;
   localparam int MAX_RES = 12;

   typedef logic [FUNC_W-1:0] func_t;
   typedef logic [PREC_W-1:0] prec_t;
   typedef logic [DAV_W-1:0]  dav_t;

   typedef enum logic [1:0] {
      ST_NEVER = 2'd0,
      ST_PEN   = 2'd1,
      ST_FREE  = 2'd2
   } start_cls_e;

   function automatic dav_t func_mask(input func_t f);
      dav_t m;
      case (f)
         4'h1:    m = 16'h0600;
         4'h2:    m = 16'h0780;
         4'h3:    m = 16'h0400;
         4'h4:    m = 16'h0200;
         4'h5:    m = 16'h0180;
         4'h6:    m = 16'h0040;
         4'h7:    m = 16'h0030;
         4'h8:    m = 16'h0010;
         4'h9:    m = 16'h0010;
         4'hA:    m = 16'h0004;
         4'hB:    m = 16'h0070;
         4'hC:    m = 16'h0002;
         default: m = 16'h0000;
      endcase
      return m;
   endfunction

   function automatic start_cls_e func_start_cls(input func_t f);
      start_cls_e c;
      case (f)
         4'h1, 4'h2, 4'h3, 4'h4, 4'h5: c = ST_PEN;
         4'h6, 4'h7, 4'h8, 4'h9,
         4'hA, 4'hB, 4'hC:             c = ST_FREE;
         default:                      c = ST_NEVER;
      endcase
      return c;
   endfunction

   function automatic logic func_one_shot(input func_t f);
      logic r;
      case (f)
         4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8, 4'hA, 4'hC: r = 1'b1;
         default:                                         r = 1'b0;
      endcase
      return r;
   endfunction

   function automatic int prec_bits(input prec_t p);
      int r;
      case (p)
         2'd1:    r = 8;
         2'd2:    r = 10;
         default: r = 12;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/tcs_conv_timer.sv
module tcs_conv_timer #(
   parameter int CONV_CYCLES = 122070
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic cancel,
   output logic busy,
   output logic done
);
   localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(CONV_CYCLES - 1);

   if (CONV_CYCLES < 1) begin : g_bad_cycles
      $error("CONV_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (cancel) begin
         busy <= 1'b0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= LOAD;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

   assign done = busy && (cnt == '0) && !cancel;

   // R5: a running count that is not cancelled keeps busy high
   p_busy_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != '0 && !cancel) |=> busy);

   // R5: completion ends the busy window
   p_done_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R4: no start request while a conversion runs
   p_no_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start);

endmodule

// File: rtl/tcs_start_ctrl.sv
module tcs_start_ctrl
   import tcs_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [14:0] cfg_wdata,
   input  logic        pen_down,
   input  logic        busy,
   input  logic        dav_any,
   output logic        enabled,
   output logic        start,
   output logic        cancel,
   output func_t       next_func,
   output prec_t       next_prec,
   output logic [7:0]  filter,
   output func_t       act_func,
   output prec_t       act_prec
);
   localparam int DIS_BIT  = 14;
   localparam int FUNC_LSB = 10;
   localparam int PREC_LSB = 8;

   start_cls_e cls;
   logic       cond_ok;
   logic       one_shot_hit;

   always_comb begin
      cls          = func_start_cls(next_func);
      cond_ok      = (cls == ST_FREE) || ((cls == ST_PEN) && pen_down);
      one_shot_hit = func_one_shot(next_func) && dav_any &&
                     ((cls != ST_PEN) || pen_down);
   end

   assign cancel = cfg_we && cfg_wdata[DIS_BIT];
   assign start  = enabled && !busy && !dav_any && cond_ok && !cfg_we;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enabled   <= 1'b0;
         next_func <= '0;
         next_prec <= '0;
         filter    <= '0;
      end else if (cfg_we) begin
         enabled   <= !cfg_wdata[DIS_BIT];
         next_func <= cfg_wdata[FUNC_LSB +: FUNC_W];
         next_prec <= cfg_wdata[PREC_LSB +: PREC_W];
         filter    <= cfg_wdata[7:0];
      end else if (one_shot_hit) begin
         enabled   <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_func <= '0;
         act_prec <= '0;
      end else if (start) begin
         act_func <= next_func;
         act_prec <= next_prec;
      end
   end

   // R4: the active settings only move on a start
   p_act_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(act_func) && $stable(act_prec)));

endmodule

// File: rtl/tcs_avail_reg.sv
module tcs_avail_reg
   import tcs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       done,
   input  func_t      act_func,
   input  logic       rd_en,
   input  logic [3:0] rd_sel,
   output dav_t       dav
);
   dav_t clr_vec;
   dav_t set_vec;

   for (genvar b = 0; b < DAV_W; b++) begin : g_clr
      if (b < NUM_CH) begin : g_chan
         assign clr_vec[b] = rd_en && (rd_sel == 4'(NUM_CH - 1 - b));

         // R6: a read of this channel clears its bit unless a completion sets it
         p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_sel == 4'(NUM_CH - 1 - b) && !done) |=> !dav[b]);
      end else begin : g_none
         assign clr_vec[b] = 1'b0;
      end
   end

   assign set_vec = done ? func_mask(act_func) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) dav <= '0;
      else        dav <= (dav & ~clr_vec) | set_vec;
   end

   // R5: completion leaves every bit of the mask set
   p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> ((dav & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/tcs_readout.sv
module tcs_readout
   import tcs_pkg::*;
#(
   parameter int RAW_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [RAW_W-1:0] raw,
   input  prec_t            prec,
   output logic [RAW_W-1:0] rd_data
);
   logic [RAW_W-1:0] cand [PREC_N];

   for (genvar p = 0; p < PREC_N; p++) begin : g_res
      localparam int RES = prec_bits(PREC_W'(p));
      localparam int SH  = RAW_W - RES;
      assign cand[p] = raw >> SH;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= cand[prec];
   end

   // R7: no result is wider than the largest resolution
   p_trunc_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> ((rd_data >> MAX_RES) == '0));

endmodule

// File: rtl/tcs_pen_pin.sv
module tcs_pen_pin (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_we,
   input  logic [1:0] pin_wdata,
   input  logic       pen_down,
   input  logic       dav_any,
   input  logic       enabled,
   output logic       pen_irq_n
);
   localparam logic [1:0] PIN_RESET = 2'd2;

   logic [1:0] pin_mode;
   logic       active;

   always_ff @(posedge clk) begin
      if (!rst_n)      pin_mode <= PIN_RESET;
      else if (pin_we) pin_mode <= pin_wdata;
   end

   always_comb begin
      case (pin_mode)
         2'd0:    active = pen_down;
         2'd1:    active = dav_any;
         default: active = pen_down && !dav_any;
      endcase
      if (!enabled) active = 1'b0;
   end

   assign pen_irq_n = !active;

endmodule

// File: rtl/touch_conv_sched.sv
module touch_conv_sched
   import tcs_pkg::*;
#(
   parameter int CONV_CYCLES = 122070,
   parameter int RAW_W       = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [14:0]      cfg_wdata,
   input  logic             pin_we,
   input  logic [1:0]       pin_wdata,
   input  logic             pen_down,
   input  logic             rd_en,
   input  logic [3:0]       rd_sel,
   input  logic [RAW_W-1:0] raw_sample,
   output logic [RAW_W-1:0] rd_data,
   output logic [15:0]      ctrl_rdata,
   output logic [15:0]      dav,
   output logic             busy,
   output logic             enabled,
   output logic             pen_irq_n,
   output logic             dav_irq_n
);
   if (RAW_W < MAX_RES) begin : g_bad_raw
      $error("RAW_W must cover the largest resolution");
   end

   logic       start;
   logic       cancel;
   logic       done;
   logic       dav_any;
   func_t      next_func;
   prec_t      next_prec;
   logic [7:0] filter;
   func_t      act_func;
   prec_t      act_prec;

   assign dav_any = |dav;

   tcs_start_ctrl u_start (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .pen_down  (pen_down),
      .busy      (busy),
      .dav_any   (dav_any),
      .enabled   (enabled),
      .start     (start),
      .cancel    (cancel),
      .next_func (next_func),
      .next_prec (next_prec),
      .filter    (filter),
      .act_func  (act_func),
      .act_prec  (act_prec)
   );

   tcs_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .cancel (cancel),
      .busy   (busy),
      .done   (done)
   );

   tcs_avail_reg u_avail (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (done),
      .act_func (act_func),
      .rd_en    (rd_en),
      .rd_sel   (rd_sel),
      .dav      (dav)
   );

   tcs_readout #(.RAW_W(RAW_W)) u_read (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .raw     (raw_sample),
      .prec    (act_prec),
      .rd_data (rd_data)
   );

   tcs_pen_pin u_pin (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_we    (pin_we),
      .pin_wdata (pin_wdata),
      .pen_down  (pen_down),
      .dav_any   (dav_any),
      .enabled   (enabled),
      .pen_irq_n (pen_irq_n)
   );

   assign ctrl_rdata = {pen_down, !busy, next_func, next_prec, filter};
   assign dav_irq_n  = !dav_any;

   // R4: a conversion only begins from an enabled block with nothing unread
   p_start_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(dav == '0 && enabled));

   // R8: a disabled block never drives the pen line
   p_pin_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !enabled |-> pen_irq_n);

   // R9: a disabling write drops any running conversion
   p_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_wdata[14]) |=> !busy);

   // R3: a pending single-channel result switches the block off
   p_oneshot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (enabled && !cfg_we && dav != '0 && next_func == 4'h6) |=> !enabled);

endmodule

// File: tb/tb_touch_conv_sched.sv
module tb_touch_conv_sched;
   localparam int CONV = 5;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [14:0] cfg_wdata;
   logic        pin_we;
   logic [1:0]  pin_wdata;
   logic        pen_down;
   logic        rd_en;
   logic [3:0]  rd_sel;
   logic [15:0] raw_sample;
   logic [15:0] rd_data;
   logic [15:0] ctrl_rdata;
   logic [15:0] dav;
   logic        busy;
   logic        enabled;
   logic        pen_irq_n;
   logic        dav_irq_n;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   touch_conv_sched #(.CONV_CYCLES(CONV), .RAW_W(16)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .pin_we(pin_we), .pin_wdata(pin_wdata), .pen_down(pen_down),
      .rd_en(rd_en), .rd_sel(rd_sel), .raw_sample(raw_sample),
      .rd_data(rd_data), .ctrl_rdata(ctrl_rdata), .dav(dav), .busy(busy),
      .enabled(enabled), .pen_irq_n(pen_irq_n), .dav_irq_n(dav_irq_n)
   );

   function automatic logic [15:0] exp_mask(input int f);
      case (f)
         1: return 16'h0600;  2: return 16'h0780;  3: return 16'h0400;
         4: return 16'h0200;  5: return 16'h0180;  6: return 16'h0040;
         7: return 16'h0030;  8: return 16'h0010;  9: return 16'h0010;
         10: return 16'h0004; 11: return 16'h0070; 12: return 16'h0002;
         default: return 16'h0000;
      endcase
   endfunction

   function automatic bit exp_starts(input int f, input bit pen);
      if (f >= 1 && f <= 5) return pen;
      return (f >= 6 && f <= 12);
   endfunction

   function automatic bit exp_single(input int f);
      return (f >= 3 && f <= 8) || f == 10 || f == 12;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; pin_we = 1'b0; pin_wdata = '0;
      pen_down = 1'b0; rd_en = 1'b0; rd_sel = '0; raw_sample = 16'hABCD;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr_cfg(input bit dis, input int f, input int p, input int filt);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = {dis, 4'(f), 2'(p), 8'(filt)};
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wr_pin(input int code);
      @(negedge clk);
      pin_we = 1'b1; pin_wdata = 2'(code);
      @(negedge clk);
      pin_we = 1'b0;
   endtask

   task automatic rd_ch(input int ch);
      @(negedge clk);
      rd_en = 1'b1; rd_sel = 4'(ch);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] prev;
      bit stayed;
      do_reset();

      // R1: reset state
      chk("R1 dav", dav, 16'h0);
      chk("R1 busy", busy, 0);
      chk("R1 enabled", enabled, 0);
      chk("R1 pen_irq_n", pen_irq_n, 1);
      chk("R1 dav_irq_n", dav_irq_n, 1);
      chk("R1 ctrl", ctrl_rdata, 16'h4000);
      wr_cfg(1'b0, 0, 0, 0);
      pen_down = 1'b1;
      idle(1);
      chk("R1 pin mode 2 pen down", pen_irq_n, 0);
      pen_down = 1'b0;
      idle(1);
      chk("R1 pin mode 2 pen up", pen_irq_n, 1);

      // R2 R3 R5: sweep every function with pen up and down
      for (int f = 0; f < 16; f++) begin
         for (int p = 0; p < 2; p++) begin
            logic [15:0] e;
            bit st;
            do_reset();
            pen_down = p[0];
            wr_cfg(1'b0, f, 0, 0);
            idle(3 * CONV);
            st = exp_starts(f, p[0]);
            e = st ? exp_mask(f) : 16'h0;
            chk($sformatf("R2 R5 dav f=%0d pen=%0d", f, p), dav, e);
            chk($sformatf("R5 dav_irq_n f=%0d pen=%0d", f, p), dav_irq_n, e == 0);
            chk($sformatf("R5 idle f=%0d pen=%0d", f, p), busy, 0);
            chk($sformatf("R3 enabled f=%0d pen=%0d", f, p), enabled,
                !(st && exp_single(f)));
         end
      end

      // R5: cycle-exact busy window
      do_reset();
      wr_cfg(1'b0, 6, 0, 0);
      chk("R5 not yet busy", busy, 0);
      @(negedge clk);
      chk("R5 busy cycle 1", busy, 1);
      for (int i = 2; i <= CONV; i++) begin
         @(negedge clk);
         chk($sformatf("R5 busy cycle %0d", i), {busy, dav}, {1'b1, 16'h0});
      end
      @(negedge clk);
      chk("R5 completion", {busy, dav}, {1'b0, 16'h0040});

      // R4: a later control write leaves the running function alone
      do_reset();
      wr_cfg(1'b0, 6, 0, 0);
      @(negedge clk);
      wr_cfg(1'b0, 7, 0, 0);
      idle(3 * CONV);
      chk("R4 active function latched", dav, 16'h0040);

      // R4: disabled never starts
      do_reset();
      wr_cfg(1'b1, 6, 0, 0);
      idle(3 * CONV);
      chk("R4 disabled no start", {busy, dav}, {1'b0, 16'h0});

      // R4: scan mode waits while data is unread
      do_reset();
      wr_cfg(1'b0, 9, 0, 0);
      idle(3 * CONV);
      stayed = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (busy) stayed = 1'b0;
      end
      chk("R4 no start with dav pending", {stayed, enabled, dav}, {1'b1, 1'b1, 16'h0010});

      // R6: per-channel clears
      do_reset();
      pen_down = 1'b1;
      wr_cfg(1'b0, 2, 0, 0);
      idle(3 * CONV);
      pen_down = 1'b0;
      chk("R6 xyz mask", dav, 16'h0780);
      rd_ch(11);
      chk("R6 code 11 ignored", dav, 16'h0780);
      prev = 16'h0780;
      for (int c = 0; c < 4; c++) begin
         rd_ch(c);
         prev = prev & ~(16'h1 << (10 - c));
         chk($sformatf("R6 clear ch %0d", c), dav, prev);
      end
      chk("R6 dav_irq_n released", dav_irq_n, 1);
      do_reset();
      wr_cfg(1'b0, 11, 0, 0);
      idle(3 * CONV);
      prev = 16'h0070;
      for (int c = 4; c < 7; c++) begin
         rd_ch(c);
         prev = prev & ~(16'h1 << (10 - c));
         chk($sformatf("R6 clear ch %0d", c), dav, prev);
      end
      do_reset();
      wr_cfg(1'b0, 10, 0, 0);
      idle(3 * CONV);
      rd_ch(9);
      chk("R6 ch 9 leaves bit 2", dav, 16'h0004);
      rd_ch(8);
      chk("R6 clear ch 8", dav, 16'h0);
      do_reset();
      wr_cfg(1'b0, 12, 0, 0);
      idle(3 * CONV);
      rd_ch(9);
      chk("R6 clear ch 9", dav, 16'h0);

      // R7: truncation per precision
      for (int p = 0; p < 4; p++) begin
         int res;
         res = (p == 1) ? 8 : (p == 2) ? 10 : 12;
         do_reset();
         raw_sample = 16'hABCD;
         wr_cfg(1'b0, 6, p, 0);
         idle(3 * CONV);
         rd_ch(4);
         chk($sformatf("R7 prec %0d", p), rd_data, 16'hABCD >> (16 - res));
      end
      do_reset();
      raw_sample = 16'h9F31;
      wr_cfg(1'b0, 6, 1, 0);
      idle(3 * CONV);
      wr_cfg(1'b1, 0, 2, 0);
      rd_ch(4);
      chk("R7 latched precision", rd_data, 16'h009F);

      // R8: pen pin modes
      do_reset();
      wr_cfg(1'b0, 0, 0, 0);
      wr_pin(0);
      pen_down = 1'b1; idle(1);
      chk("R8 mode 0 pen down", pen_irq_n, 0);
      pen_down = 1'b0; idle(1);
      chk("R8 mode 0 pen up", pen_irq_n, 1);
      wr_pin(1);
      chk("R8 mode 1 no data", pen_irq_n, 1);
      wr_cfg(1'b0, 9, 0, 0);
      idle(3 * CONV);
      chk("R8 mode 1 data", pen_irq_n, 0);
      wr_pin(3);
      pen_down = 1'b1; idle(1);
      chk("R8 mode 3 pen down data pending", pen_irq_n, 1);
      wr_pin(0);
      chk("R8 mode 0 pen down data pending", pen_irq_n, 0);
      wr_cfg(1'b1, 9, 0, 0);
      chk("R8 disabled forces inactive", pen_irq_n, 1);
      pen_down = 1'b0;

      // R9: cancel
      do_reset();
      wr_cfg(1'b0, 6, 0, 0);
      @(negedge clk);
      chk("R9 running", busy, 1);
      wr_cfg(1'b1, 6, 0, 0);
      chk("R9 busy dropped", busy, 0);
      idle(3 * CONV);
      chk("R9 no data", dav, 16'h0);

      // R10: control readback
      do_reset();
      wr_cfg(1'b1, 11, 2, 8'h5A);
      chk("R10 readback pen up", ctrl_rdata, 16'h6E5A);
      pen_down = 1'b1; idle(1);
      chk("R10 readback pen down", ctrl_rdata, 16'hEE5A);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule